// File: doc/BRIEF.md
# Thermal Throttle Status Controller

This block watches a digital temperature code and decides when thermal throttling is in force. Throttling starts at the clock edge that first sees the temperature at or above a programmable trip level. It stays on for at least a fixed number of cycles, set by a parameter that stands for about a millisecond of real time. It turns off only once that time has passed and the temperature has fallen below the trip level by at least a programmable margin.

Software reads a small status word. That word holds a live engaged flag and a sticky log flag. The log flag records that a trip has happened, and a write clears it. Two single-cycle interrupt pulses mark the temperature crossing the trip level, one for upward crossings and one for downward crossings, and each has its own enable.

The block also forwards requests to change performance state. In the immediate mode it forwards every request at once. In the deferred mode it holds a request made during throttling and releases it once throttling ends. Only the latest such request is kept.

Top module: `thermal_guard`

## Requirements
- R1: While `reg_rd` is high, `reg_rdata` bit 0 equals `engaged`, bit 1 equals the log flag, and all higher bits are 0. While `reg_rd` is low, `reg_rdata` is all zero.
- R2: The log flag sets on every edge where `temp >= trip_level` and the previous sampled temperature was below `trip_level`. A write (`reg_wr`) with `reg_wdata` bit 1 at 0 clears the log flag. Writing 1 to bit 1, or any value to bit 0, has no effect.
- R3: When a trip and a clearing write happen on the same edge, the log flag ends up set.
- R4: `engaged` rises at the edge that samples `temp >= trip_level` while `engaged` is low. Once risen, it stays high for at least `HOLD` cycles.
- R5: `engaged` falls at the first edge where it has already been high for `HOLD` or more cycles and `temp + hyst_margin < trip_level`. This comparison is made without overflow, so a margin larger than the trip level never allows release.
- R6: `irq_hot` is a one-cycle pulse after each edge where the temperature crosses from below `trip_level` to at or above it, provided `hot_irq_en` is high at that edge.
- R7: `irq_cool` is a one-cycle pulse after each edge where the temperature crosses from at or above `trip_level` to below it, provided `cool_irq_en` is high at that edge.
- R8: With `defer_mode` at 0, a request (`ps_req`) produces `ps_grant` and `ps_out = ps_val` on the next cycle, whether or not throttling is engaged.
- R9: With `defer_mode` at 1, a request made while `engaged` is high is held. It is granted with its value one cycle after `engaged` is seen low, or after `defer_mode` goes to 0. A request made while not engaged is granted on the next cycle.
- R10: Only one request is held. A newer request that is deferred replaces the held value, and a request that is granted directly discards the held one.
- R11: While `rst_n` is low, and just after it rises, `engaged`, the log flag, both interrupts and `ps_grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp | input | TW | Temperature code |
| trip_level | input | TW | Trip threshold |
| hyst_margin | input | TW | Release hysteresis margin |
| defer_mode | input | 1 | 0 = immediate grants, 1 = defer while engaged |
| hot_irq_en | input | 1 | Enable upward-crossing interrupt |
| cool_irq_en | input | 1 | Enable downward-crossing interrupt |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | RW | Status write data |
| reg_rdata | output | RW | Status read data |
| ps_req | input | 1 | Performance-state request strobe |
| ps_val | input | PW | Requested performance state |
| ps_grant | output | 1 | One-cycle grant pulse |
| ps_out | output | PW | Granted performance state |
| engaged | output | 1 | Throttling engaged |
| irq_hot | output | 1 | Upward-crossing interrupt pulse |
| irq_cool | output | 1 | Downward-crossing interrupt pulse |

## Verification
The hardest case to reach from the ports is a deferred request being replaced and then released. This needs throttling engaged in deferred mode, two requests during one hold window, and then a cool-down that gets past both the hold count and the hysteresis margin. The stimulus uses a short hold parameter. It moves the temperature as a slow random walk around the trip level and issues frequent requests while switching modes now and then. Directed sequences follow for a trip that coincides with a clearing write and for a margin larger than the trip level.

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int TW   = 8,
  parameter int PW   = 4,
  parameter int RW   = 8,
  parameter int HOLD = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] trip_level,
  input  logic [TW-1:0] hyst_margin,
  input  logic          defer_mode,
  input  logic          hot_irq_en,
  input  logic          cool_irq_en,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          ps_req,
  input  logic [PW-1:0] ps_val,
  output logic          ps_grant,
  output logic [PW-1:0] ps_out,
  output logic          engaged,
  output logic          irq_hot,
  output logic          irq_cool
);
  localparam int CW = $clog2(HOLD + 1);

  logic          hot, cool, hot_q, log_q, pend;
  logic [CW-1:0] hold_cnt;
  logic [PW-1:0] pend_val;

  assign hot  = temp >= trip_level;
  assign cool = ({1'b0, temp} + {1'b0, hyst_margin}) < {1'b0, trip_level};
  assign reg_rdata = reg_rd ? {{(RW-2){1'b0}}, log_q, engaged} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_q    <= 1'b0;
      engaged  <= 1'b0;
      hold_cnt <= '0;
      log_q    <= 1'b0;
      irq_hot  <= 1'b0;
      irq_cool <= 1'b0;
      ps_grant <= 1'b0;
      ps_out   <= '0;
      pend     <= 1'b0;
      pend_val <= '0;
    end else begin
      hot_q    <= hot;
      irq_hot  <= hot_irq_en && hot && !hot_q;
      irq_cool <= cool_irq_en && !hot && hot_q;

      if (!engaged && hot) begin
        engaged  <= 1'b1;
        hold_cnt <= CW'(HOLD - 1);
      end else if (engaged) begin
        if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
        else if (cool)      engaged  <= 1'b0;
      end

      if (hot && !hot_q)                log_q <= 1'b1;
      else if (reg_wr && !reg_wdata[1]) log_q <= 1'b0;

      ps_grant <= 1'b0;
      if (ps_req) begin
        if (defer_mode && engaged) begin
          pend     <= 1'b1;
          pend_val <= ps_val;
        end else begin
          pend     <= 1'b0;
          ps_grant <= 1'b1;
          ps_out   <= ps_val;
        end
      end else if (pend && (!engaged || !defer_mode)) begin
        pend     <= 1'b0;
        ps_grant <= 1'b1;
        ps_out   <= pend_val;
      end
    end
  end

  logic [CW-1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)                        age <= '0;
    else if (!engaged)                 age <= '0;
    else if (age < CW'(HOLD))          age <= age + 1'b1;
  end

  assert_min_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(engaged) |-> $past(age) >= CW'(HOLD - 1));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(engaged) |-> $past(cool));
  assert_log_on_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(engaged) |-> log_q);
  assert_hot_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hot |=> !irq_hot);
  assert_cool_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cool |=> !irq_cool);
  assert_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ps_grant |-> !($past(defer_mode) && $past(engaged)));
  assert_rdata_R1: assert property (@(posedge clk)
    !reg_rd |-> reg_rdata == '0);
endmodule

// File: tb/tb_thermal_guard.sv
module tb_thermal_guard;
  localparam int TW = 8, PW = 4, RW = 8, HOLD = 12;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] temp = 0, trip_level = 100, hyst_margin = 8;
  logic defer_mode = 0, hot_irq_en = 1, cool_irq_en = 1, reg_rd = 0, reg_wr = 0, ps_req = 0;
  logic [RW-1:0] reg_wdata = 0;
  logic [PW-1:0] ps_val = 0;
  logic [RW-1:0] reg_rdata;
  logic ps_grant, engaged, irq_hot, irq_cool;
  logic [PW-1:0] ps_out;

  thermal_guard #(.TW(TW), .PW(PW), .RW(RW), .HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .temp(temp), .trip_level(trip_level), .hyst_margin(hyst_margin),
    .defer_mode(defer_mode), .hot_irq_en(hot_irq_en), .cool_irq_en(cool_irq_en),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ps_req(ps_req), .ps_val(ps_val), .ps_grant(ps_grant), .ps_out(ps_out),
    .engaged(engaged), .irq_hot(irq_hot), .irq_cool(irq_cool));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_eng, m_hotq, m_log, m_ih, m_ic, m_gnt, m_pend;
  int m_hi;
  logic [PW-1:0] m_out, m_pval;

  function automatic bit is_hot(logic [TW-1:0] t, logic [TW-1:0] tr);
    return t >= tr;
  endfunction
  function automatic bit is_cool(logic [TW-1:0] t, logic [TW-1:0] tr, logic [TW-1:0] h);
    return (int'(t) + int'(h)) < int'(tr);
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_step();
    bit h, c, trip;
    if (!rst_n) begin
      m_eng = 0; m_hotq = 0; m_log = 0; m_ih = 0; m_ic = 0; m_gnt = 0;
      m_pend = 0; m_hi = 0; m_out = 0; m_pval = 0;
      return;
    end
    h = is_hot(temp, trip_level);
    c = is_cool(temp, trip_level, hyst_margin);
    trip = h && !m_hotq;
    m_ih = hot_irq_en && trip;
    m_ic = cool_irq_en && !h && m_hotq;
    m_gnt = 0;
    if (ps_req) begin
      if (defer_mode && m_eng) begin m_pend = 1; m_pval = ps_val; end
      else begin m_pend = 0; m_gnt = 1; m_out = ps_val; end
    end else if (m_pend && (!m_eng || !defer_mode)) begin
      m_pend = 0; m_gnt = 1; m_out = m_pval;
    end
    if (!m_eng && h) begin m_eng = 1; m_hi = 1; end
    else if (m_eng) begin
      if (m_hi >= HOLD && c) begin m_eng = 0; m_hi = 0; end
      else m_hi++;
    end
    if (trip) m_log = 1;
    else if (reg_wr && !reg_wdata[1]) m_log = 0;
    m_hotq = h;
  endtask

  task automatic cycle();
    chk("R4/R5 engaged", engaged, m_eng);
    chk("R6 irq_hot", irq_hot, m_ih);
    chk("R7 irq_cool", irq_cool, m_ic);
    chk("R8/R9 ps_grant", ps_grant, m_gnt);
    if (m_gnt) chk("R10 ps_out", ps_out, m_out);
    #1;
    chk("R1 reg_rdata", reg_rdata, reg_rd ? {m_log, m_eng} : 0);
    model_step();
    @(negedge clk);
  endtask

  task automatic read_log(string req, bit exp);
    reg_rd = 1; reg_wr = 0; ps_req = 0;
    #1; chk(req, reg_rdata[1], exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    model_step();
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      reg_rd = 1; temp = 120;
      chk("R11 reset engaged", engaged, 0);
      cycle();
    end
    rst_n = 1; temp = 0; reg_rd = 1;
    chk("R11 after reset irq_hot", irq_hot, 0);
    cycle();

    // random phase
    temp = 90;
    for (int i = 0; i < 8000; i++) begin
      int step;
      step = int'($urandom_range(0, 6)) - 3;
      if (int'(temp) + step < 70) temp = 70;
      else if (int'(temp) + step > 125) temp = 125;
      else temp = TW'(int'(temp) + step);
      if ($urandom_range(0, 199) == 0) defer_mode = ~defer_mode;
      if ($urandom_range(0, 99) == 0) hyst_margin = TW'($urandom_range(0, 15));
      hot_irq_en = $urandom_range(0, 3) != 0;
      cool_irq_en = $urandom_range(0, 3) != 0;
      reg_rd = $urandom_range(0, 1);
      reg_wr = $urandom_range(0, 15) == 0;
      reg_wdata = RW'($urandom);
      ps_req = $urandom_range(0, 5) == 0;
      ps_val = PW'($urandom);
      cycle();
    end

    // directed: R3 trip and clear on same edge
    defer_mode = 1; ps_req = 0; reg_wr = 0; hyst_margin = 8;
    temp = 50;
    for (int i = 0; i < HOLD + 4; i++) cycle();
    reg_wr = 1; reg_wdata = 0; cycle();
    read_log("R2 log cleared by write 0", 0);
    cycle();
    temp = 110; reg_wr = 1; reg_wdata = 0; cycle();
    read_log("R3 set wins over clear", 1);
    cycle();
    reg_wr = 1; reg_wdata = 8'h02; cycle();
    read_log("R2 write 1 keeps log", 1);
    cycle();
    // R10 replacement in defer mode while engaged
    ps_req = 1; ps_val = 4'h3; cycle();
    ps_req = 1; ps_val = 4'h9; cycle();
    ps_req = 0; temp = 50;
    for (int i = 0; i < HOLD + 4; i++) begin
      cycle();
      if (ps_grant) chk("R10 replaced value", ps_out, 4'h9);
    end
    chk("R5 released", engaged, 0);
    // R5 margin larger than trip never releases
    trip_level = 5; hyst_margin = 20; temp = 6; cycle();
    temp = 0;
    for (int i = 0; i < HOLD * 3; i++) cycle();
    chk("R5 oversized margin holds", engaged, 1);
    hyst_margin = 2;
    for (int i = 0; i < 3; i++) cycle();
    chk("R5 release after margin drop", engaged, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule